// File: doc/BRIEF.md
# Flag-Driven Jump Condition Decoder

This block turns a 4-bit condition code from the microcode sequencer into a single jump decision. It looks at the four arithmetic flags: zero, overflow, sign and carry. The decision goes out on one active-low line. When the line is low, the sequencer loads the program counter. When it is high, execution falls through to the next step.

The code space holds fifteen tests: an unconditional jump, four signed comparisons, two unsigned comparisons, and eight tests of a single flag being set or clear. The last code is reserved. An enable input from the microcode qualifies the whole decision, so the sequencer can leave a stale code on the bus without causing a jump.

The decoder is purely combinational. Its output follows its inputs within the same cycle and keeps no history.

Top module: `jcond_decoder`

## Requirements
- R1: While `cond_en` is 0, `jump_n` is 1 for every code and every flag value.
- R2: With `cond_en` at 1, code 0 drives `jump_n` to 0 whatever the flags are.
- R3: The flag bus is `flags[3]` zero (Z), `flags[2]` overflow (O), `flags[1]` sign (S), `flags[0]` carry (C). Code 1 jumps when Z=1 or S differs from O. Code 2 jumps when Z=0 and S equals O.
- R4: Code 3 jumps when S equals O. Code 4 jumps when S differs from O (flag bit order as in R3).
- R5: Code 5 jumps when both C and Z are 0. Code 6 jumps when C=1 or Z=1 (flag bit order as in R3).
- R6: Code 7 jumps when C=0. Code 8 jumps when C=1 (C is `flags[0]`).
- R7: Code 9 jumps when Z=0. Code 10 (0xA) jumps when Z=1 (Z is `flags[3]`).
- R8: Code 11 (0xB) jumps when S=0. Code 12 (0xC) jumps when S=1 (S is `flags[1]`).
- R9: Code 13 (0xD) jumps when O=0. Code 14 (0xE) jumps when O=1 (O is `flags[2]`).
- R10: Code 15 (0xF) is reserved, and `jump_n` stays 1 for every flag value.
- R11: A jump is signalled by `jump_n`=0 and no jump by `jump_n`=1. The value depends only on the present inputs, with no dependence on earlier inputs and no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_en | input | 1 | Qualifies the decision; 0 forces no jump |
| cond_code | input | 4 | Selected jump condition, 0x0 to 0xF |
| flags | input | 4 | {Z, O, S, C} flag values |
| jump_n | output | 1 | Active-low jump taken |

## Verification
Every result of this decoder is due zero cycles after its stimulus. `jump_n` settles in the same cycle that the code, enable or flags change. The bench applies each input set just after a falling clock edge and waits one nanosecond for settling. It then samples well before the next rising edge, so no register stage is assumed anywhere. For the history check, the bench applies a fixed input set after two different predecessors and expects the same value both times.

// File: rtl/jcond_pkg.sv
package jcond_pkg;

  localparam int CODE_W  = 4;
  localparam int FLAG_W  = 4;

  // Flag bus positions, decoded by the flag register neighbour
  localparam int FLG_Z = 3;
  localparam int FLG_O = 2;
  localparam int FLG_S = 1;
  localparam int FLG_C = 0;

  typedef enum logic [CODE_W-1:0] {
    JC_ALWAYS = 4'h0,
    JC_SLE    = 4'h1,
    JC_SGT    = 4'h2,
    JC_SGE    = 4'h3,
    JC_SLT    = 4'h4,
    JC_UGT    = 4'h5,
    JC_ULE    = 4'h6,
    JC_NCARRY = 4'h7,
    JC_CARRY  = 4'h8,
    JC_NZERO  = 4'h9,
    JC_ZERO   = 4'hA,
    JC_NSIGN  = 4'hB,
    JC_SIGN   = 4'hC,
    JC_NOVF   = 4'hD,
    JC_OVF    = 4'hE,
    JC_RSVD   = 4'hF
  } jcond_e;

endpackage

// File: rtl/jcond_relations.sv
module jcond_relations
  import jcond_pkg::*;
#(
  parameter int NUM_CODES = 16
) (
  input  logic [FLAG_W-1:0]    flags,
  output logic [NUM_CODES-1:0] cond_vec
);

  logic z, o, s, c;
  logic sgn_lt, uns_le;

  assign z = flags[FLG_Z];
  assign o = flags[FLG_O];
  assign s = flags[FLG_S];
  assign c = flags[FLG_C];

  // shared terms: signed less-than and unsigned below-or-equal
  assign sgn_lt = s ^ o;
  assign uns_le = c | z;

  always_comb begin
    cond_vec            = '0;
    cond_vec[JC_ALWAYS] = 1'b1;
    cond_vec[JC_SLE]    = z | sgn_lt;
    cond_vec[JC_SGT]    = ~(z | sgn_lt);
    cond_vec[JC_SGE]    = ~sgn_lt;
    cond_vec[JC_SLT]    = sgn_lt;
    cond_vec[JC_UGT]    = ~uns_le;
    cond_vec[JC_ULE]    = uns_le;
    cond_vec[JC_NCARRY] = ~c;
    cond_vec[JC_CARRY]  = c;
    cond_vec[JC_NZERO]  = ~z;
    cond_vec[JC_ZERO]   = z;
    cond_vec[JC_NSIGN]  = ~s;
    cond_vec[JC_SIGN]   = s;
    cond_vec[JC_NOVF]   = ~o;
    cond_vec[JC_OVF]    = o;
    // JC_RSVD and anything above stays 0
  end

endmodule

// File: rtl/jcond_select.sv
module jcond_select #(
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 16
) (
  input  logic [CODE_W-1:0]    code,
  input  logic [NUM_CODES-1:0] cond_vec,
  output logic                 hit
);

  logic [NUM_CODES-1:0] gated;

  // one-hot decode of the code, each slot gated by its condition
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_slot
    assign gated[i] = (code == CODE_W'(i)) & cond_vec[i];
  end

  assign hit = |gated;

endmodule

// File: rtl/jcond_decoder.sv
module jcond_decoder
  import jcond_pkg::*;
(
  input  logic              cond_en,
  input  logic [CODE_W-1:0] cond_code,
  input  logic [FLAG_W-1:0] flags,
  output logic              jump_n
);

  localparam int NUM_CODES = 1 << CODE_W;

  logic [NUM_CODES-1:0] cond_vec;
  logic                 hit;

  jcond_relations #(
    .NUM_CODES (NUM_CODES)
  ) rel_i (
    .flags    (flags),
    .cond_vec (cond_vec)
  );

  jcond_select #(
    .CODE_W    (CODE_W),
    .NUM_CODES (NUM_CODES)
  ) sel_i (
    .code     (cond_code),
    .cond_vec (cond_vec),
    .hit      (hit)
  );

  assign jump_n = ~(cond_en & hit);

endmodule

// File: rtl/jcond_decoder_chk.sv
module jcond_decoder_chk
  import jcond_pkg::*;
(
  input logic              cond_en,
  input logic [CODE_W-1:0] cond_code,
  input logic [FLAG_W-1:0] flags,
  input logic              jump_n
);

  logic known;
  assign known = !$isunknown({cond_en, cond_code, flags});

  always_comb begin
    if (known) begin
      // R1
      a_r1_disabled_no_jump: assert (cond_en || jump_n);
      // R2
      a_r2_always_jumps: assert (!(cond_en && cond_code == 4'h0) || !jump_n);
      // R10
      a_r10_reserved_never: assert (cond_code != 4'hF || jump_n);
      // R4
      a_r4_sge_relation: assert (!(cond_en && cond_code == 4'h3)
                                 || (jump_n == (flags[FLG_S] != flags[FLG_O])));
      // R7
      a_r7_zero_relation: assert (!(cond_en && cond_code == 4'hA)
                                  || (jump_n == !flags[FLG_Z]));
      // R6
      a_r6_carry_relation: assert (!(cond_en && cond_code == 4'h8)
                                   || (jump_n == !flags[FLG_C]));
    end
  end

endmodule

bind jcond_decoder jcond_decoder_chk chk_i (
  .cond_en   (cond_en),
  .cond_code (cond_code),
  .flags     (flags),
  .jump_n    (jump_n)
);

// File: tb/jcond_decoder_tb_top.sv
`timescale 1ns/1ps
module jcond_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cond_en;
  logic [3:0] cond_code;
  logic [3:0] flags;
  logic       jump_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  jcond_decoder dut_i (
    .cond_en   (cond_en),
    .cond_code (cond_code),
    .flags     (flags),
    .jump_n    (jump_n)
  );

  // expected jump decision from the requirements; flags = {Z,O,S,C}
  function automatic logic want_jump(input logic [3:0] code, input logic [3:0] f);
    logic z, o, s, c;
    z = f[3]; o = f[2]; s = f[1]; c = f[0];
    case (code)
      4'h0: return 1'b1;
      4'h1: return z || (s != o);
      4'h2: return !z && (s == o);
      4'h3: return s == o;
      4'h4: return s != o;
      4'h5: return !c && !z;
      4'h6: return c || z;
      4'h7: return !c;
      4'h8: return c;
      4'h9: return !z;
      4'hA: return z;
      4'hB: return !s;
      4'hC: return s;
      4'hD: return !o;
      4'hE: return o;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'h0: return "R2";
      4'h1, 4'h2: return "R3";
      4'h3, 4'h4: return "R4";
      4'h5, 4'h6: return "R5";
      4'h7, 4'h8: return "R6";
      4'h9, 4'hA: return "R7";
      4'hB, 4'hC: return "R8";
      4'hD, 4'hE: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic en, input logic [3:0] code, input logic [3:0] f);
    @(negedge clk);
    cond_en = en; cond_code = code; flags = f;
    #1;
  endtask

  task automatic check(input string req, input logic exp_n);
    n_checks++;
    if (jump_n !== exp_n) begin
      n_fail++;
      $display("FAIL %s: en=%0b code=%h flags=%b jump_n=%b expected=%b",
               req, cond_en, cond_code, flags, jump_n, exp_n);
    end
  endtask

  task automatic test_idle_state;
    apply(1'b0, 4'h0, 4'h0);
    check("R1", 1'b1);
  endtask

  task automatic test_disabled;
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 16; f++) begin
        apply(1'b0, 4'(code), 4'(f));
        check("R1", 1'b1);
      end
  endtask

  task automatic test_codes(input int lo, input int hi);
    for (int code = lo; code <= hi; code++)
      for (int f = 0; f < 16; f++) begin
        apply(1'b1, 4'(code), 4'(f));
        check(req_of(4'(code)), !want_jump(4'(code), 4'(f)));
      end
  endtask

  task automatic test_history;
    // same final inputs after opposite predecessors: R11
    apply(1'b1, 4'h0, 4'h0);
    apply(1'b1, 4'h1, 4'b0010);
    check("R11", 1'b0);
    apply(1'b0, 4'hF, 4'hF);
    apply(1'b1, 4'h1, 4'b0010);
    check("R11", 1'b0);
    apply(1'b1, 4'hA, 4'b1000);
    check("R11", 1'b0);
    flags = 4'b0000;
    #1;
    check("R11", 1'b1);
  endtask

  initial begin
    cond_en = 1'b0; cond_code = 4'h0; flags = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    test_idle_state();
    test_disabled();
    test_codes(0, 0);
    test_codes(1, 2);
    test_codes(3, 4);
    test_codes(5, 6);
    test_codes(7, 8);
    test_codes(9, 10);
    test_codes(11, 12);
    test_codes(13, 14);
    test_codes(15, 15);
    test_history();
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule